// File: doc/BRIEF.md
# Serial Auto-Baud Calibration and Lock Handshake

This block watches a serial receive line and works out the bit period of a host that has not yet agreed on a rate. The host opens by sending a single all-zero byte. With standard framing, that byte holds the line low for nine bit times: the start bit plus eight zero data bits. The block counts system clocks across that low stretch. It divides the count by nine, rounding to the nearest integer, to get a bit period in clocks. It then requires the line to stay high for at least one full measured bit time before it accepts the measurement.

Once the measurement is accepted, the block replies at the measured rate with an all-zero acknowledge byte. It then listens at that rate for a confirmation byte of 0x55. When the confirmation arrives intact, the block commits the period to its divisor output and raises a lock flag that holds until reset.

Any failure raises a one-clock error pulse and sends the block back to measuring. Failures include:
- a period that fits neither supported host rate;
- a high gap that is too short;
- a wrong confirmation byte;
- a bad stop bit;
- silence that outlasts the timeout.

Top module: `autobaud_lock`

## Requirements
- R1: While reset is held and on the first clock after it, `locked_o` is 0, `divisor_o` is 0, `err_o` is 0 and `txd_o` is high.
- R2: The bit period is floor((L+4)/9), where L is the number of clocks the synchronised line is sampled low. On lock, `divisor_o` takes this value. It reads 0 while unlocked.
- R3: A period outside every window `base ± base*TOL_PCT/100` (integer arithmetic) is rejected with one error pulse and no acknowledge. Here `base = CLK_HZ/9600` or `base = CLK_HZ/19200`.
- R4: If the line falls before it has been high for one full period after the low stretch, the block raises one error pulse, sends no acknowledge and restarts measuring.
- R5: After acceptance, `txd_o` sends 0x00 with one start bit and one high stop bit, each bit one period long. The line is therefore low for exactly 9 periods.
- R6: The confirmation frame is received at the measured rate. Bits are sampled near mid-bit, data comes LSB first, and one stop bit follows. The value 0x55 with a high stop bit sets `locked_o`.
- R7: A confirmation value other than 0x55 raises one error pulse, leaves the block unlocked and returns it to measuring. A later valid calibration then locks normally.
- R8: A confirmation frame whose stop bit samples low raises one error pulse and does not lock.
- R9: If no start bit arrives within TIMEOUT_BITS periods of entering the confirmation wait, the block raises one error pulse and returns to measuring.
- R10: Once locked, `locked_o` and `divisor_o` hold until reset, `txd_o` stays high, and further line activity has no effect.
- R11: `err_o` is a single-clock pulse and is never high while `locked_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line from the host (idle high) |
| txd_o | output | 1 | Serial line to the host (idle high) |
| divisor_o | output | CNT_W | Committed bit period in clocks, 0 until locked |
| locked_o | output | 1 | Handshake complete, held until reset |
| err_o | output | 1 | One-clock pulse on any calibration or handshake failure |

## Verification
The checker watches these properties on every clock:
- the lock flag never drops once set;
- the divisor stays frozen and non-zero only while locked;
- the transmit line stays idle after lock;
- the error signal is a single-clock pulse that never coincides with lock;
- the reset values are correct.

Other behaviour depends on whole frames and can only be shown by the bench scenarios. These are the rounding of the low count, the acceptance windows at their edges, the exact length of the acknowledge, and the outcome of a confirmation byte that is correct, wrong, badly framed or missing. For that reason the bench sweeps the calibration length across both rate windows and their rounding edges.

// File: rtl/ab_pkg.sv
package ab_pkg;

    typedef enum logic [2:0] {
        ST_ARM  = 3'd0,
        ST_WAIT = 3'd1,
        ST_LOW  = 3'd2,
        ST_HIGH = 3'd3,
        ST_ACK  = 3'd4,
        ST_CONF = 3'd5,
        ST_LOCK = 3'd6
    } ab_state_e;

    localparam int unsigned NUM_RATES = 2;
    localparam int unsigned HOST_RATES [NUM_RATES] = '{9600, 19200};
    localparam logic [7:0]  ACK_CODE     = 8'h00;
    localparam logic [7:0]  CONFIRM_CODE = 8'h55;
    localparam int unsigned LOW_BITS     = 9;

endpackage

// File: rtl/ab_period_calc.sv
module ab_period_calc #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned CLK_HZ  = 20_000_000,
    parameter int unsigned TOL_PCT = 4
) (
    input  logic [CNT_W-1:0] low_cnt_i,
    output logic [CNT_W-1:0] period_o,
    output logic             in_window_o
);
    import ab_pkg::*;

    localparam logic [CNT_W:0] DIVIDE = (CNT_W+1)'(LOW_BITS);
    localparam logic [CNT_W:0] HALF   = (CNT_W+1)'(LOW_BITS / 2);

    logic [CNT_W:0]           biased;
    logic [CNT_W:0]           quot;
    logic [NUM_RATES-1:0]     hit;

    assign biased   = {1'b0, low_cnt_i} + HALF;
    assign quot     = biased / DIVIDE;
    assign period_o = quot[CNT_W-1:0];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam int unsigned BASE = CLK_HZ / HOST_RATES[g];
        localparam int unsigned SPAN = BASE * TOL_PCT / 100;
        localparam logic [CNT_W-1:0] LO = CNT_W'(BASE - SPAN);
        localparam logic [CNT_W-1:0] HI = CNT_W'(BASE + SPAN);
        assign hit[g] = (period_o >= LO) && (period_o <= HI);
    end

    assign in_window_o = |hit;

endmodule

// File: rtl/ab_tx.sv
module ab_tx #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       data_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             txd_o,
    output logic             done_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       nb;
        logic [9:0]       sh;
        logic             done;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.nb   = '0;
                d.sh   = {1'b1, data_i, 1'b0};
            end
        end else if (q.cnt == period_i - 1'b1) begin
            d.cnt = '0;
            d.sh  = {1'b1, q.sh[9:1]};
            if (q.nb == 4'd9) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.nb = q.nb + 1'b1;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign txd_o  = q.busy ? q.sh[0] : 1'b1;
    assign done_o = q.done;

endmodule

// File: rtl/ab_rx.sv
module ab_rx #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rxd_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ferr_o,
    output logic [7:0]       data_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       idx;
        logic [7:0]       sh;
        logic             done;
        logic             ferr;
    } rx_s;

    rx_s q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!en_i) begin
            d.run = 1'b0;
        end else if (!q.run) begin
            if (!rxd_i) begin
                d.run = 1'b1;
                d.cnt = period_i >> 1;
                d.idx = '0;
            end
        end else if (q.cnt == '0) begin
            d.cnt = period_i - 1'b1;
            if (q.idx == 4'd0) begin
                if (rxd_i) begin
                    d.run = 1'b0;
                end else begin
                    d.idx = 4'd1;
                end
            end else if (q.idx <= 4'd8) begin
                d.sh  = {rxd_i, q.sh[7:1]};
                d.idx = q.idx + 1'b1;
            end else begin
                d.done = 1'b1;
                d.ferr = !rxd_i;
                d.run  = 1'b0;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.run;
    assign done_o = q.done;
    assign ferr_o = q.ferr;
    assign data_o = q.sh;

endmodule

// File: rtl/autobaud_lock.sv
module autobaud_lock #(
    parameter int unsigned CLK_HZ       = 20_000_000,
    parameter int unsigned TOL_PCT      = 4,
    parameter int unsigned TIMEOUT_BITS = 20,
    parameter int unsigned CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_i,
    output logic             txd_o,
    output logic [CNT_W-1:0] divisor_o,
    output logic             locked_o,
    output logic             err_o
);
    import ab_pkg::*;

    localparam int unsigned TW = CNT_W + $clog2(TIMEOUT_BITS + 1);

    typedef struct packed {
        ab_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] div;
        logic             lock;
        logic             err;
        logic             tx_go;
        logic [TW-1:0]    tmo;
        logic [1:0]       sync;
    } top_s;

    top_s q, d;

    logic             rx_s;
    logic [CNT_W-1:0] calc_per;
    logic             calc_ok;
    logic             tx_done;
    logic             rx_busy;
    logic             rx_done;
    logic             rx_ferr;
    logic [7:0]       rx_data;
    logic [TW-1:0]    tmo_lim;

    assign rx_s    = q.sync[1];
    assign tmo_lim = TW'(q.per) * TW'(TIMEOUT_BITS);

    ab_period_calc #(
        .CNT_W   (CNT_W),
        .CLK_HZ  (CLK_HZ),
        .TOL_PCT (TOL_PCT)
    ) u_calc (
        .low_cnt_i   (q.cnt),
        .period_o    (calc_per),
        .in_window_o (calc_ok)
    );

    ab_tx #(.CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (q.tx_go),
        .data_i   (ACK_CODE),
        .period_i (q.per),
        .txd_o    (txd_o),
        .done_o   (tx_done)
    );

    ab_rx #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (q.st == ST_CONF),
        .rxd_i    (rx_s),
        .period_i (q.per),
        .busy_o   (rx_busy),
        .done_o   (rx_done),
        .ferr_o   (rx_ferr),
        .data_o   (rx_data)
    );

    always_comb begin
        d       = q;
        d.err   = 1'b0;
        d.tx_go = 1'b0;
        d.sync  = {q.sync[0], rxd_i};
        unique case (q.st)
            ST_ARM: begin
                if (rx_s) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (!rx_s) begin
                    d.st  = ST_LOW;
                    d.cnt = CNT_W'(1);
                end
            end
            ST_LOW: begin
                if (!rx_s) begin
                    if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
                end else begin
                    d.per = calc_per;
                    if (calc_ok) begin
                        d.st  = ST_HIGH;
                        d.cnt = CNT_W'(1);
                    end else begin
                        d.st  = ST_ARM;
                        d.err = 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (!rx_s) begin
                    d.st  = ST_ARM;
                    d.err = 1'b1;
                end else if (q.cnt == q.per - 1'b1) begin
                    d.st    = ST_ACK;
                    d.tx_go = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_ACK: begin
                if (tx_done) begin
                    d.st  = ST_CONF;
                    d.tmo = '0;
                end
            end
            ST_CONF: begin
                if (rx_done) begin
                    if (!rx_ferr && rx_data == CONFIRM_CODE) begin
                        d.st   = ST_LOCK;
                        d.lock = 1'b1;
                        d.div  = q.per;
                    end else begin
                        d.st  = ST_ARM;
                        d.err = 1'b1;
                    end
                end else if (rx_busy) begin
                    d.tmo = '0;
                end else if (q.tmo == tmo_lim - 1'b1) begin
                    d.st  = ST_ARM;
                    d.err = 1'b1;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
            ST_LOCK: begin
                d.st = ST_LOCK;
            end
            default: begin
                d.st = ST_ARM;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign divisor_o = q.div;
    assign locked_o  = q.lock;
    assign err_o     = q.err;

endmodule

// File: rtl/autobaud_lock_chk.sv
module autobaud_lock_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd_o,
    input logic [CNT_W-1:0] divisor_o,
    input logic             locked_o,
    input logic             err_o
);
    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (!locked_o && !err_o && txd_o && divisor_o == '0));

    assert_div_zero_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |-> divisor_o == '0);

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    assert_div_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> $stable(divisor_o));

    assert_tx_idle_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> txd_o);

    assert_err_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    assert_err_not_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> !err_o);

endmodule

bind autobaud_lock autobaud_lock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd_o     (txd_o),
    .divisor_o (divisor_o),
    .locked_o  (locked_o),
    .err_o     (err_o)
);

// File: tb/sim_autobaud_lock.sv
module sim_autobaud_lock;
    localparam int CLK_HZ = 960_000;
    localparam int TOL    = 4;
    localparam int TMO    = 20;
    localparam int CW     = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          txd;
    logic [CW-1:0] divisor;
    logic          locked;
    logic          err;

    int total = 0;
    int bad = 0;
    int errcnt = 0;
    int txlow = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    autobaud_lock #(
        .CLK_HZ(CLK_HZ), .TOL_PCT(TOL), .TIMEOUT_BITS(TMO), .CNT_W(CW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_o(txd),
        .divisor_o(divisor), .locked_o(locked), .err_o(err)
    );

    always @(negedge clk) begin
        if (rst_n && err) errcnt++;
        if (rst_n && !txd) txlow++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rxd   = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic calib(input int low, input int high);
        @(negedge clk);
        rxd = 1'b0;
        repeat (low) @(negedge clk);
        rxd = 1'b1;
        repeat (high) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] b, input int p, input bit stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (p) @(negedge clk);
        end
        rxd = stop;
        repeat (p) @(negedge clk);
        rxd = 1'b1;
    endtask

    function automatic bit in_win(input int p);
        int b1 = CLK_HZ / 9600;
        int b2 = CLK_HZ / 19200;
        int s1 = b1 * TOL / 100;
        int s2 = b2 * TOL / 100;
        return (p >= b1 - s1 && p <= b1 + s1) || (p >= b2 - s2 && p <= b2 + s2);
    endfunction

    task automatic sweep_one(input int low);
        int pe = (low + 4) / 9;
        int e0, t0;
        do_reset();
        e0 = errcnt;
        t0 = txlow;
        calib(low, 0);
        repeat (12 * pe + 10) @(negedge clk);
        if (in_win(pe)) begin
            chk(txlow - t0 == 9 * pe, "R5 ack low length", txlow - t0, 9 * pe);
            chk(errcnt == e0, "R2 accepted period no error", errcnt - e0, 0);
        end else begin
            chk(txlow == t0, "R3 rejected period sends no ack", txlow - t0, 0);
            chk(errcnt - e0 == 1, "R3 rejected period error pulse", errcnt - e0, 1);
        end
    endtask

    initial begin
        int e0, t0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!locked && !err && txd && divisor == 0, "R1 reset outputs",
            int'(locked), 0);
        rst_n = 1'b1;

        // R2 R3 R5: sweep calibration length across both windows and rounding edges
        for (int p = 44; p <= 56; p++) sweep_one(9 * p);
        for (int p = 92; p <= 108; p++) sweep_one(9 * p);
        sweep_one(427); sweep_one(428); sweep_one(472); sweep_one(473);
        sweep_one(859); sweep_one(860); sweep_one(940); sweep_one(941);

        // R6 R2: full handshake at 9600-equivalent
        do_reset();
        e0 = errcnt;
        calib(900, 0);
        repeat (1220) @(negedge clk);
        frame(8'h55, 100, 1'b1);
        repeat (200) @(negedge clk);
        chk(locked, "R6 lock after confirm", int'(locked), 1);
        chk(divisor == 100, "R2 divisor committed", int'(divisor), 100);
        chk(errcnt == e0, "R6 no error in handshake", errcnt - e0, 0);

        // R10: activity after lock has no effect
        t0 = txlow;
        calib(900, 200);
        frame(8'h00, 100, 1'b1);
        repeat (1500) @(negedge clk);
        chk(locked && divisor == 100, "R10 lock and divisor held", int'(divisor), 100);
        chk(txlow == t0, "R10 no further transmit", txlow - t0, 0);
        chk(errcnt == e0, "R10 no error after lock", errcnt - e0, 0);

        // R2: rounding of a non-multiple count, fast rate
        do_reset();
        calib(445, 0);
        repeat (12 * 49 + 20) @(negedge clk);
        frame(8'h55, 49, 1'b1);
        repeat (100) @(negedge clk);
        chk(locked && divisor == 49, "R2 rounded divisor 445/9", int'(divisor), 49);

        // R7: wrong confirm value then recovery
        do_reset();
        e0 = errcnt;
        calib(900, 0);
        repeat (1220) @(negedge clk);
        frame(8'h54, 100, 1'b1);
        repeat (200) @(negedge clk);
        chk(!locked, "R7 wrong confirm not locked", int'(locked), 0);
        chk(errcnt - e0 == 1, "R7 wrong confirm error", errcnt - e0, 1);
        calib(900, 0);
        repeat (1220) @(negedge clk);
        frame(8'h55, 100, 1'b1);
        repeat (200) @(negedge clk);
        chk(locked && divisor == 100, "R7 relock after restart", int'(divisor), 100);

        // R8: stop bit low
        do_reset();
        e0 = errcnt;
        calib(900, 0);
        repeat (1220) @(negedge clk);
        frame(8'h55, 100, 1'b0);
        repeat (200) @(negedge clk);
        chk(!locked, "R8 framing error not locked", int'(locked), 0);
        chk(errcnt - e0 == 1, "R8 framing error pulse", errcnt - e0, 1);

        // R9: timeout while waiting for confirm
        do_reset();
        e0 = errcnt;
        calib(900, 0);
        repeat (3000) @(negedge clk);
        chk(errcnt == e0, "R9 no error before timeout", errcnt - e0, 0);
        repeat (200) @(negedge clk);
        chk(errcnt - e0 == 1, "R9 timeout error", errcnt - e0, 1);
        chk(!locked, "R9 not locked after timeout", int'(locked), 0);

        // R4: high gap shorter than one period
        do_reset();
        e0 = errcnt;
        t0 = txlow;
        calib(900, 50);
        calib(200, 300);
        chk(errcnt - e0 == 1, "R4 short high error", errcnt - e0, 1);
        chk(txlow == t0, "R4 short high no ack", txlow - t0, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule